// File: doc/BRIEF.md
# Accumulator Machine Math Execute Unit

This block carries out the arithmetic and logic class of instructions for a small accumulator machine. It holds the machine's 8-bit accumulator and its 16-bit address register, which serves as a data pointer. The fetch stage hands the block an opcode byte and an assembled 16-bit operand with a one-cycle `start` strobe. The block picks a source value and a destination value from independently chosen locations, combines them in one of eight functions and writes the result back to the destination.

Every access to data memory uses one shared byte-wide port. The port has registered address, write-enable and write-data outputs, and read data comes back from a synchronous memory one cycle after an address is presented. When an operand lives in memory, the block reads it first. When the destination is a memory byte, the block reads that byte, computes the result and writes it back to the same address. The block raises `done` for one cycle when the instruction has finished. Opcodes that are not math instructions finish at once and change nothing.

Top module: `math_exec_unit`

## Requirements
- R1: The opcode is laid out as bit 7 = math class, bits 6:5 = source, bits 4:3 = destination and bits 2:0 = function. An opcode with bit 7 clear changes no register and writes no memory, and `done` is high in the cycle after the `start` edge.
- R2: Function codes: 000 AND, 001 OR, 010 XOR, 011 ADD, 100 SUB, 101 INC, 110 DEC, 111 NOT.
- R3: Source codes: 00 = memory byte at the address held in the pointer register, 01 = accumulator, 10 = constant from the operand, 11 = memory byte at the 16-bit operand address.
- R4: Destination codes: 00 = memory byte at the pointer address, 01 = accumulator, 10 = the 16-bit pointer register itself, 11 = memory byte at the operand address.
- R5: Binary functions compute destination op source, with the destination value on the left (SUB is destination minus source). INC, DEC and NOT act on the destination value alone, and the source has no effect on the result.
- R6: When the pointer register is the destination, the operation is 16 bits wide. A constant source then uses all 16 operand bits, and byte sources are zero-extended.
- R7: ADD, SUB, INC and DEC wrap modulo 2^8 for byte destinations and modulo 2^16 for the pointer register.
- R8: A memory destination is a read-modify-write. The block issues a read of the destination byte, then a single one-cycle write pulse to the same address. No other memory byte changes.
- R9: `done` is a single-cycle pulse. It goes high 3 cycles after the `start` edge for an instruction whose operands are both registers or constants, plus 2 cycles for a memory source and plus 2 cycles for a memory destination. A `start` that arrives while an instruction is in progress is ignored.
- R10: After synchronous reset, the accumulator and pointer register are 0, and `done` and the memory write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented instruction |
| opcode | input | 8 | Instruction opcode byte |
| operand | input | 16 | Assembled operand (constant or address) |
| acc | output | 8 | Accumulator contents |
| mar | output | 16 | Pointer register contents |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| done | output | 1 | Instruction complete, one-cycle pulse |

## Verification
The assertions check on every cycle that `done` and the write enable are single-cycle pulses, and that a memory write is followed by `done`. They also check that the write address is held from the destination read through the write, and that the accumulator and pointer register change only at completion. They check that a non-math opcode completes in the next cycle without writing. Only the bench scenarios can show that the value computed for each source, destination and function pairing is correct, including wraparound, 16-bit pointer arithmetic, zero-extension and the disregarded source of unary functions. The bench scenarios also show that the latency depends on the memory operands, and that a second `start` during an instruction leaves the result untouched.

// File: rtl/math_exec_pkg.sv
package math_exec_pkg;

  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_XOR = 3'b010,
    FN_ADD = 3'b011,
    FN_SUB = 3'b100,
    FN_INC = 3'b101,
    FN_DEC = 3'b110,
    FN_NOT = 3'b111
  } fn_e;

  typedef enum logic [1:0] {
    SRC_PTR = 2'b00,
    SRC_ACC = 2'b01,
    SRC_IMM = 2'b10,
    SRC_ABS = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    DST_PTR = 2'b00,
    DST_ACC = 2'b01,
    DST_MAR = 2'b10,
    DST_ABS = 2'b11
  } dst_e;

  // Field order is decoded by the fetch stage, so it is fixed (R1).
  typedef struct packed {
    logic is_math;
    src_e src;
    dst_e dst;
    fn_e  fn;
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_ADDR,
    ST_SRC_DATA,
    ST_DST_ADDR,
    ST_DST_DATA,
    ST_EXEC,
    ST_FIN
  } state_e;

endpackage

// File: rtl/math_alu.sv
module math_alu
  import math_exec_pkg::*;
#(
  parameter int W = 16
) (
  input  fn_e          fn,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (fn)
      FN_AND:  res = lhs & rhs;
      FN_OR:   res = lhs | rhs;
      FN_XOR:  res = lhs ^ rhs;
      FN_ADD:  res = lhs + rhs;
      FN_SUB:  res = lhs - rhs;
      FN_INC:  res = lhs + ONE;
      FN_DEC:  res = lhs - ONE;
      default: res = ~lhs;
    endcase
  end

endmodule

// File: rtl/math_ctrl.sv
module math_ctrl
  import math_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_t               op_in,
  input  logic [ADDR_W-1:0] operand_in,
  input  logic [ADDR_W-1:0] ptr_cur,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] result_byte,
  output src_e              q_src,
  output dst_e              q_dst,
  output fn_e               q_fn,
  output logic [ADDR_W-1:0] q_operand,
  output logic [DATA_W-1:0] src_byte,
  output logic [DATA_W-1:0] dst_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              acc_we,
  output logic              mar_we,
  output logic              done
);

  state_e state;

  function automatic logic src_in_mem(src_e s);
    return (s == SRC_PTR) || (s == SRC_ABS);
  endfunction

  function automatic logic dst_in_mem(dst_e d);
    return (d == DST_PTR) || (d == DST_ABS);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      q_src     <= SRC_PTR;
      q_dst     <= DST_PTR;
      q_fn      <= FN_AND;
      q_operand <= '0;
      src_byte  <= '0;
      dst_byte  <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      acc_we    <= 1'b0;
      mar_we    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      acc_we <= 1'b0;
      mar_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            q_src     <= op_in.src;
            q_dst     <= op_in.dst;
            q_fn      <= op_in.fn;
            q_operand <= operand_in;
            if (!op_in.is_math) begin
              done <= 1'b1;
            end else if (src_in_mem(op_in.src)) begin
              mem_addr <= (op_in.src == SRC_PTR) ? ptr_cur : operand_in;
              state    <= ST_SRC_ADDR;
            end else if (dst_in_mem(op_in.dst)) begin
              mem_addr <= (op_in.dst == DST_PTR) ? ptr_cur : operand_in;
              state    <= ST_DST_ADDR;
            end else begin
              state <= ST_EXEC;
            end
          end
        end
        ST_SRC_ADDR: state <= ST_SRC_DATA;
        ST_SRC_DATA: begin
          src_byte <= mem_rdata;
          if (dst_in_mem(q_dst)) begin
            mem_addr <= (q_dst == DST_PTR) ? ptr_cur : q_operand;
            state    <= ST_DST_ADDR;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_DST_ADDR: state <= ST_DST_DATA;
        ST_DST_DATA: begin
          dst_byte <= mem_rdata;
          state    <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (q_dst)
            DST_ACC: acc_we <= 1'b1;
            DST_MAR: mar_we <= 1'b1;
            default: begin
              mem_we    <= 1'b1;
              mem_wdata <= result_byte;
            end
          endcase
          state <= ST_FIN;
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we) else $error("write enable longer than one cycle"); // R8

  AST_WE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> done) else $error("write not followed by done"); // R8

  AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $stable(mem_addr)) else $error("write address moved after read"); // R8

  AST_NOP_QUICK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && !op_in.is_math) |=> (done && !mem_we))
    else $error("non-math opcode mishandled"); // R1

endmodule

// File: rtl/math_exec_unit.sv
module math_exec_unit
  import math_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] mar,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done
);

  localparam int PAD_W = ADDR_W - DATA_W;

  src_e              q_src;
  dst_e              q_dst;
  fn_e               q_fn;
  logic [ADDR_W-1:0] q_operand;
  logic [DATA_W-1:0] src_byte, dst_byte;
  logic              acc_we, mar_we;
  logic [ADDR_W-1:0] src_val, dst_val, result;

  math_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_in      (op_t'(opcode)),
    .operand_in (operand),
    .ptr_cur    (mar),
    .mem_rdata  (mem_rdata),
    .result_byte(result[DATA_W-1:0]),
    .q_src      (q_src),
    .q_dst      (q_dst),
    .q_fn       (q_fn),
    .q_operand  (q_operand),
    .src_byte   (src_byte),
    .dst_byte   (dst_byte),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .acc_we     (acc_we),
    .mar_we     (mar_we),
    .done       (done)
  );

  // Source selection; constants widen only for the pointer destination (R6).
  always_comb begin
    unique case (q_src)
      SRC_ACC: src_val = {{PAD_W{1'b0}}, acc};
      SRC_IMM: src_val = (q_dst == DST_MAR) ? q_operand
                                            : {{PAD_W{1'b0}}, q_operand[DATA_W-1:0]};
      default: src_val = {{PAD_W{1'b0}}, src_byte};
    endcase
  end

  always_comb begin
    unique case (q_dst)
      DST_ACC: dst_val = {{PAD_W{1'b0}}, acc};
      DST_MAR: dst_val = mar;
      default: dst_val = {{PAD_W{1'b0}}, dst_byte};
    endcase
  end

  math_alu #(.W(ADDR_W)) alu_i (
    .fn (q_fn),
    .lhs(dst_val),
    .rhs(src_val),
    .res(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      mar <= '0;
    end else begin
      if (acc_we) acc <= result[DATA_W-1:0];
      if (mar_we) mar <= result;
    end
  end

  AST_ACC_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc) |-> done) else $error("accumulator changed mid-instruction"); // R4

  AST_MAR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(mar) |-> done) else $error("pointer changed mid-instruction"); // R6

endmodule

// File: tb/math_exec_unit_tb.sv
module math_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] operand = '0;
  logic [7:0]  acc, mem_wdata;
  logic [15:0] mar, mem_addr;
  logic        mem_we, done;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem   [256];
  logic [7:0]  mem_m [256];
  logic [7:0]  acc_m;
  logic [15:0] mar_m;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  math_exec_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .operand(operand),
    .acc(acc), .mar(mar), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  // Synchronous byte memory, aliased on the low address byte.
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Expected behaviour from the requirements (R2..R7); returns latency (R9).
  task automatic model(input logic [7:0] op, input logic [15:0] opd, output int lat);
    logic [1:0]  s, d;
    logic [2:0]  f;
    logic [15:0] sv, dv, r;
    s = op[6:5]; d = op[4:3]; f = op[2:0];
    if (!op[7]) begin
      lat = 1;
      return;
    end
    case (s)
      2'd0: sv = {8'h0, mem_m[mar_m[7:0]]};
      2'd1: sv = {8'h0, acc_m};
      2'd2: sv = (d == 2'd2) ? opd : {8'h0, opd[7:0]};
      default: sv = {8'h0, mem_m[opd[7:0]]};
    endcase
    case (d)
      2'd0: dv = {8'h0, mem_m[mar_m[7:0]]};
      2'd1: dv = {8'h0, acc_m};
      2'd2: dv = mar_m;
      default: dv = {8'h0, mem_m[opd[7:0]]};
    endcase
    case (f)
      3'd0: r = dv & sv;
      3'd1: r = dv | sv;
      3'd2: r = dv ^ sv;
      3'd3: r = dv + sv;
      3'd4: r = dv - sv;
      3'd5: r = dv + 16'd1;
      3'd6: r = dv - 16'd1;
      default: r = ~dv;
    endcase
    case (d)
      2'd0: mem_m[mar_m[7:0]] = r[7:0];
      2'd1: acc_m = r[7:0];
      2'd2: mar_m = r;
      default: mem_m[opd[7:0]] = r[7:0];
    endcase
    lat = 3 + ((s == 2'd0 || s == 2'd3) ? 2 : 0) + ((d == 2'd0 || d == 2'd3) ? 2 : 0);
  endtask

  task automatic run(input logic [7:0] op, input logic [15:0] opd, input bit poke,
                     input string req);
    int lat, cyc, mism;
    model(op, opd, lat);
    @(negedge clk);
    opcode = op; operand = opd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (poke && !done) begin
      opcode = 8'hC1; operand = 16'h00FF; start = 1'b1;  // ignored while busy (R9)
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1 && cyc == lat, "R9", "done latency", cyc, lat);
    @(negedge clk);
    check(!done, "R9", "done width", done, 0);
    check(acc == acc_m, req, "acc", acc, acc_m);
    check(mar == mar_m, req, "mar", mar, mar_m);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== mem_m[i]) mism++;
    check(mism == 0, "R8", "memory bytes differing", mism, 0);
  endtask

  function automatic logic [7:0] opc(input int s, input int d, input int f);
    return {1'b1, 2'(s), 2'(d), 3'(f)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4717));
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 37 + 5);
      mem_m[i] = 8'(i * 37 + 5);
    end
    acc_m = '0; mar_m = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(acc == 0 && mar == 0, "R10", "reset registers", {acc, mar}, 0);
    check(!done && !mem_we, "R10", "reset strobes", {done, mem_we}, 0);

    run(8'h21, 16'h0055, 1'b0, "R1");          // non-math: no change
    run(opc(2, 1, 1), 16'h00F0, 1'b0, "R3");    // acc |= F0
    run(opc(2, 1, 2), 16'h00FF, 1'b0, "R2");    // acc ^= FF -> 0F
    run(opc(2, 1, 3), 16'hAAF1, 1'b0, "R7");    // acc + F1 wraps
    run(opc(2, 1, 4), 16'h0001, 1'b0, "R5");    // acc - 1
    run(opc(2, 2, 3), 16'h1234, 1'b0, "R6");    // mar += 16-bit const
    run(opc(1, 2, 1), 16'h0000, 1'b0, "R6");    // mar |= zext acc
    run(opc(2, 2, 0), 16'h0000, 1'b0, "R7");    // mar = 0
    run(opc(2, 2, 6), 16'h0000, 1'b0, "R7");    // mar dec wraps to FFFF
    run(opc(2, 2, 5), 16'h7777, 1'b0, "R5");    // inc, source disregarded
    run(opc(3, 1, 7), 16'h0010, 1'b0, "R5");    // not, source disregarded
    run(opc(1, 3, 3), 16'h0040, 1'b0, "R8");    // mem[40] += acc
    run(opc(0, 0, 5), 16'h0000, 1'b0, "R4");    // mem[mar] ++
    run(opc(3, 0, 4), 16'h0081, 1'b0, "R4");    // mem[mar] -= mem[81]
    run(opc(0, 1, 3), 16'h0000, 1'b1, "R9");    // busy start ignored
    run(opc(2, 3, 6), 16'hAB00, 1'b1, "R9");

    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if ((k % 10) != 0) op[7] = 1'b1;
      run(op, 16'($urandom), (k % 7) == 0, op[7] ? "R2" : "R1");
    end
    summary();
  end

endmodule